// File: doc/BRIEF.md
# Receive Word Latch with Two-Half Bus Readout

This block sits between a serial word decoder and a 16-bit host data bus. When the decoder signals the end of a 32-bit word with a one-cycle strobe, the block can capture that word. An optional label filter compares received bits 9 and 10 against two configured bits and discards any word that does not match. An accepted word is stored and an active-low ready flag is pulled low.

The host reads the stored word as two 16-bit halves. It pulls the active-low enable low and uses the select input to choose a half. The first half carries a scattered set of word bits (bits 9..13, the parity bit 32, bits 30 and 31, and bits 1..8). The second half carries bits 14..29 in a straight run. The ready flag returns high only once both halves have been read, in either order. A word that is captured before the host finishes reading replaces the stored word and restarts the read bookkeeping.

The bus is only driven while the enable is low. This is modelled as an output-enable signal next to a data vector that is zero when the bus is not driven. The asynchronous reset is released through a local synchronizer.

Top module: `rx_word_latch`

## Requirements
- R1: With `filt_en` low, or with `filt_en` high and `rx_word[8]==match_cfg[0]` and `rx_word[9]==match_cfg[1]` (word bit n at index n-1), a high `eos` at a clock edge stores `rx_word` and drives `rdy_n` low after that edge.
- R2: With `filt_en` high and bits 9/10 differing from `match_cfg`, an `eos` leaves the stored word and `rdy_n` unchanged.
- R3: With `en_n` low and `sel` low, `bus_dat[15:11]` = word bits 13,12,11,10,9; `bus_dat[10]` = bit 31; `bus_dat[9]` = bit 30; `bus_dat[8]` = bit 32; `bus_dat[7:0]` = bits 1..8 (bit 1 on `bus_dat[7]`).
- R4: With `en_n` low and `sel` high, `bus_dat[15:0]` = word bits 29 down to 14.
- R5: `bus_oe` equals the inverse of `en_n`, and `bus_dat` is all zero while `en_n` is high.
- R6: A half counts as read at each clock edge where `en_n` is low and a word is pending, with `sel` choosing the half. `rdy_n` rises after the edge that completes the second distinct half, in either order, and never without a read.
- R7: An accepted `eos` while a word is pending overwrites the stored word and keeps `rdy_n` low.
- R8: An accepted capture forgets any half already read, so both halves of the new word must be read before `rdy_n` rises.
- R9: After reset `rdy_n` is high and the stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| eos | input | 1 | End-of-word strobe from decoder |
| rx_word | input | 32 | Decoded word, index n-1 holds word bit n |
| filt_en | input | 1 | Enable bits 9/10 label filter |
| match_cfg | input | 2 | Expected bits: [0] vs bit 9, [1] vs bit 10 |
| sel | input | 1 | Half select, 0 = first half, 1 = second half |
| en_n | input | 1 | Active-low bus read enable |
| rdy_n | output | 1 | Active-low word-pending flag |
| bus_oe | output | 1 | Bus drive enable |
| bus_dat | output | 16 | Bus data |

## Verification
The bus data and its enable are combinational from `sel`, `en_n` and the stored word. The bench checks them a short delay after driving the inputs, before the next rising edge. Capture and read tracking each take one register stage, so `rdy_n` is checked at the falling edge after the edge that sampled `eos` or the read. The sweep covers every combination of filter enable, received label, configured label and read order. Separate sequences cover overwrite, forgotten reads and idle bus behaviour.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned HALVES = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  // word bit n lives at index n-1
  function automatic half_t first_half(input word_t w);
    half_t h;
    h[15] = w[12];
    h[14] = w[11];
    h[13] = w[10];
    h[12] = w[9];
    h[11] = w[8];
    h[10] = w[30];
    h[9]  = w[29];
    h[8]  = w[31];
    for (int k = 0; k < 8; k++) h[7-k] = w[k];
    return h;
  endfunction

  function automatic half_t second_half(input word_t w);
    half_t h;
    for (int k = 0; k < HALF_W; k++) h[k] = w[k+13];
    return h;
  endfunction
endpackage

// File: rtl/rxl_rst_sync.sv
module rxl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rxl_capture.sv
module rxl_capture
  import rxl_pkg::*;
#(
  parameter int unsigned LBL_POS = 8,
  parameter int unsigned LBL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eos,
  input  word_t            word_in,
  input  logic             filt_en,
  input  logic [LBL_W-1:0] match,
  output logic             cap,
  output word_t            word_q
);
  logic  hit;
  word_t word_d;

  always_comb begin
    hit    = !filt_en || (word_in[LBL_POS +: LBL_W] == match);
    cap    = eos && hit;
    word_d = word_q;
    if (cap) word_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= '0;
    else if (cap) word_q <= word_d;
  end
endmodule

// File: rtl/rxl_read_track.sv
module rxl_read_track
  import rxl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic en_n,
  input  logic sel,
  output logic rdy_n
);
  logic              valid_q, valid_d;
  logic [HALVES-1:0] seen_q, seen_d;

  always_comb begin
    valid_d = valid_q;
    seen_d  = seen_q;
    if (cap) begin
      valid_d = 1'b1;
      seen_d  = '0;
    end else if (valid_q && !en_n) begin
      seen_d[sel] = 1'b1;
      if (&seen_d) begin
        valid_d = 1'b0;
        seen_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      seen_q  <= '0;
    end else begin
      valid_q <= valid_d;
      seen_q  <= seen_d;
    end
  end

  assign rdy_n = !valid_q;
endmodule

// File: rtl/rxl_bus_mux.sv
module rxl_bus_mux
  import rxl_pkg::*;
(
  input  word_t word,
  input  logic  sel,
  input  logic  en_n,
  output logic  oe,
  output half_t dat
);
  always_comb begin
    oe  = !en_n;
    dat = '0;
    if (oe) dat = sel ? second_half(word) : first_half(word);
  end
endmodule

// File: rtl/rx_word_latch.sv
module rx_word_latch
  import rxl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LBL_POS     = 8,
  parameter int unsigned LBL_W       = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             eos,
  input  logic [31:0]      rx_word,
  input  logic             filt_en,
  input  logic [LBL_W-1:0] match_cfg,
  input  logic             sel,
  input  logic             en_n,
  output logic             rdy_n,
  output logic             bus_oe,
  output logic [15:0]      bus_dat
);
  logic  rst_n_sync;
  logic  cap;
  word_t word_q;

  rxl_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n_sync)
  );

  rxl_capture #(.LBL_POS(LBL_POS), .LBL_W(LBL_W)) i_cap (
    .clk(clk), .rst_n(rst_n_sync), .eos(eos), .word_in(rx_word),
    .filt_en(filt_en), .match(match_cfg), .cap(cap), .word_q(word_q)
  );

  rxl_read_track i_trk (
    .clk(clk), .rst_n(rst_n_sync), .cap(cap), .en_n(en_n), .sel(sel),
    .rdy_n(rdy_n)
  );

  rxl_bus_mux i_mux (
    .word(word_q), .sel(sel), .en_n(en_n), .oe(bus_oe), .dat(bus_dat)
  );
endmodule

// File: rtl/rxl_checker.sv
module rxl_checker #(
  parameter int unsigned LBL_POS = 8,
  parameter int unsigned LBL_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eos,
  input logic [31:0]      rx_word,
  input logic             filt_en,
  input logic [LBL_W-1:0] match_cfg,
  input logic             en_n,
  input logic             rdy_n,
  input logic             bus_oe,
  input logic [15:0]      bus_dat,
  input logic [31:0]      word_q
);
  logic lbl_ok;
  assign lbl_ok = (rx_word[LBL_POS +: LBL_W] == match_cfg);

  assert_capture_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && (!filt_en || lbl_ok)) |=> !rdy_n);

  assert_reject_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && filt_en && !lbl_ok && en_n) |=> (rdy_n == $past(rdy_n)) && $stable(word_q));

  assert_idle_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (!bus_oe && bus_dat == 16'h0));

  assert_rise_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> $past(!en_n));

  assert_pending_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && en_n) |=> !rdy_n);
endmodule

bind rx_word_latch rxl_checker #(.LBL_POS(LBL_POS), .LBL_W(LBL_W)) i_chk (
  .clk(clk), .rst_n(rst_n_sync), .eos(eos), .rx_word(rx_word),
  .filt_en(filt_en), .match_cfg(match_cfg), .en_n(en_n), .rdy_n(rdy_n),
  .bus_oe(bus_oe), .bus_dat(bus_dat), .word_q(word_q)
);

// File: tb/test_rx_word_latch.sv
module test_rx_word_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        eos;
  logic [31:0] rx_word;
  logic        filt_en;
  logic [1:0]  match_cfg;
  logic        sel;
  logic        en_n;
  logic        rdy_n;
  logic        bus_oe;
  logic [15:0] bus_dat;

  int errors = 0;
  int checks = 0;
  logic [31:0] model_word;
  logic [31:0] seed;

  rx_word_latch i_rx_word_latch (
    .clk(clk), .arst_n(arst_n), .eos(eos), .rx_word(rx_word),
    .filt_en(filt_en), .match_cfg(match_cfg), .sel(sel), .en_n(en_n),
    .rdy_n(rdy_n), .bus_oe(bus_oe), .bus_dat(bus_dat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_half(input logic [31:0] w, input logic s);
    logic [15:0] h;
    if (s) begin
      h = w[28:13];
    end else begin
      h = {w[12], w[11], w[10], w[9], w[8], w[30], w[29], w[31],
           w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
    end
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic capture(input logic [31:0] w);
    eos = 1'b1; rx_word = w;
    #1;
    chk("R5 idle during eos", {31'd0, bus_oe}, 32'd0);
    chk("R5 idle data", {16'd0, bus_dat}, 32'd0);
    tick();
    eos = 1'b0;
  endtask

  task automatic read_half(input string req, input logic s);
    sel = s; en_n = 1'b0;
    #1;
    chk("R5 drive", {31'd0, bus_oe}, 32'd1);
    chk(req, {16'd0, bus_dat}, {16'd0, exp_half(model_word, s)});
    tick();
    en_n = 1'b1;
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    arst_n = 1'b0; eos = 1'b0; rx_word = '0; filt_en = 1'b0;
    match_cfg = 2'b00; sel = 1'b0; en_n = 1'b1;
    seed = 32'h1357_9bdf;
    model_word = '0;
    repeat (3) tick();
    arst_n = 1'b1;
    repeat (4) tick();

    // R9 reset state
    chk("R9 rdy_n after reset", {31'd0, rdy_n}, 32'd1);
    chk("R9 oe idle after reset", {31'd0, bus_oe}, 32'd0);
    read_half("R9 stored word zero", 1'b0);
    chk("R9 no pending after read", {31'd0, rdy_n}, 32'd1);

    // sweep filter enable x received label x configured label x read order
    for (int i = 0; i < 64; i++) begin
      logic f;
      logic [1:0] lbl, mc;
      logic ord, acc;
      logic [31:0] w;
      f   = i[0];
      lbl = i[2:1];
      mc  = i[4:3];
      ord = i[5];
      seed = next_rand(seed);
      w = seed;
      w[9:8] = lbl;
      acc = !f || (lbl == mc);
      filt_en = f; match_cfg = mc;
      capture(w);
      if (acc) begin
        model_word = w;
        chk("R1 rdy_n after accepted eos", {31'd0, rdy_n}, 32'd0);
      end else begin
        chk("R2 rdy_n unchanged on mismatch", {31'd0, rdy_n}, 32'd1);
      end
      read_half(ord ? "R4 second half" : "R3 first half", ord);
      chk("R6 after one half", {31'd0, rdy_n}, {31'd0, !acc});
      read_half(ord ? "R3 first half" : "R4 second half", !ord);
      chk("R6 after both halves", {31'd0, rdy_n}, 32'd1);
    end

    // R6: same half twice does not clear
    filt_en = 1'b0;
    seed = next_rand(seed);
    model_word = seed;
    capture(seed);
    read_half("R3 repeat read", 1'b0);
    read_half("R3 repeat read", 1'b0);
    chk("R6 same half twice keeps pending", {31'd0, rdy_n}, 32'd0);
    tick();
    chk("R6 idle keeps pending", {31'd0, rdy_n}, 32'd0);
    read_half("R4 complete", 1'b1);
    chk("R6 cleared", {31'd0, rdy_n}, 32'd1);

    // R7 overwrite
    seed = next_rand(seed);
    capture(seed);
    seed = next_rand(seed);
    model_word = seed;
    capture(seed);
    chk("R7 still pending after overwrite", {31'd0, rdy_n}, 32'd0);
    read_half("R7 overwritten first half", 1'b0);
    read_half("R7 overwritten second half", 1'b1);
    chk("R7 cleared", {31'd0, rdy_n}, 32'd1);

    // R8 capture forgets earlier half read
    seed = next_rand(seed);
    model_word = seed;
    capture(seed);
    read_half("R8 first half old", 1'b0);
    seed = next_rand(seed);
    model_word = seed;
    capture(seed);
    read_half("R8 second half new", 1'b1);
    chk("R8 pending after one half of new word", {31'd0, rdy_n}, 32'd0);
    read_half("R8 first half new", 1'b0);
    chk("R8 cleared", {31'd0, rdy_n}, 32'd1);

    // R2 rejected word while pending: pending word kept
    seed = next_rand(seed);
    model_word = seed;
    capture(seed);
    filt_en = 1'b1; match_cfg = ~model_word[9:8];
    seed = next_rand(seed);
    begin
      logic [31:0] bad;
      bad = seed;
      bad[9:8] = model_word[9:8];
      capture(bad);
    end
    chk("R2 pending kept", {31'd0, rdy_n}, 32'd0);
    read_half("R2 word kept first", 1'b0);
    read_half("R2 word kept second", 1'b1);
    chk("R2 cleared", {31'd0, rdy_n}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule